// File: doc/BRIEF.md
# Frame-Transfer CCD Vertical Sequencer

This block runs the vertical side of a frame-transfer CCD for one frame. A trigger starts the frame. The block first raises a charge-reset strobe for a programmable number of master clocks, which empties the light-sensitive section and starts exposure. An integration wait of programmable length follows. The block then moves every line of the image section down into the shielded storage section. During that move both the image-phase and the storage-phase clock groups toggle together, and a transport-boost flag asks the analog drivers for the larger clock swing.

Readout follows, one line at a time. For each line the storage phases shift once while the horizontal run enable stays low. The block then raises that enable and waits until the horizontal generator reports that the line has been consumed. A frame marker covers the first readout line. A one-cycle clamp strobe opens each line read. After the last line the block goes back to idle and waits for the next trigger.

Every line shift lasts 8 sub-steps of `SUBSTEP_CYC` master clocks each. The four phases of a group follow one another in a rotating pattern with a 5/8 high duty cycle.

Top module: `ccd_vseq`

## Requirements
- R1: After reset, and in idle between frames, every output is 0: `img_ph`, `sto_ph`, `xfer_boost`, `chg_rst`, `frame_mark`, `clamp`, `hrun`.
- R2: A `frame_start` pulse sampled in idle makes `chg_rst` high from the next cycle for max(`cr_cycles`,1) cycles. All other outputs stay low during that time.
- R3: Once `chg_rst` falls, every output stays low for max(`int_cycles`,1) cycles. This is the integration wait.
- R4: After integration, `xfer_boost` is high for exactly `N_LINES`×8×`SUBSTEP_CYC` cycles. During that window `img_ph` equals `sto_ph` on every cycle, and `hrun` is low.
- R5: Within each line shift, sub-step s (0..7) lasts `SUBSTEP_CYC` cycles and starts at 0. During sub-step s, bit k (k = 0..3) of an active phase bus is 1 exactly when (s − 2k) mod 8 lies in 0..4. Each phase is therefore high for 5 of 8 sub-steps, and the phases are offset by 2 sub-steps.
- R6: Each of the `N_LINES` readout lines begins with a storage-only shift of 8×`SUBSTEP_CYC` cycles following the R5 pattern. During this shift `img_ph` is 0 and both `xfer_boost` and `hrun` are low.
- R7: After each storage-only shift, `hrun` stays high until the cycle after `line_done` is sampled high. `line_done` has no effect while `hrun` is low: the line shift still runs its full length.
- R8: `clamp` is high for exactly one cycle per readout line, on the first cycle of `hrun`.
- R9: `frame_mark` is high during the shift and the read of the first readout line of a frame, and is low at all other times.
- R10: After the read of line `N_LINES` the block returns to idle. A `frame_start` pulse that arrives while a frame is in progress is ignored and does not start a second frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Frame trigger, sampled in idle |
| line_done | input | 1 | Horizontal generator has consumed the current line |
| cr_cycles | input | TMR_W | Charge-reset length in master clocks (0 acts as 1) |
| int_cycles | input | TMR_W | Integration length in master clocks (0 acts as 1) |
| img_ph | output | 4 | Image-section phase clocks |
| sto_ph | output | 4 | Storage-section phase clocks |
| xfer_boost | output | 1 | High-amplitude select while image phases transport charge |
| chg_rst | output | 1 | Charge-reset strobe |
| frame_mark | output | 1 | Frame marker, first readout line |
| clamp | output | 1 | Black-level clamp strobe |
| hrun | output | 1 | Horizontal clocks may run; low during line shifts |

## Verification
The hardest situation to reach from the ports is a `line_done` or `frame_start` that arrives while the block is busy elsewhere. Examples are `line_done` held high through a storage-only shift, or a trigger arriving in the middle of the frame transfer. To reach these cases, some table rows switch on a noise flag. With the flag set, the bench drives `line_done` high for the whole of every line shift and pulses `frame_start` during the transfer. The bench then measures the full shift length and checks that idle follows the frame. Another case is a reset that lands partway through the frame transfer. A directed test covers it and then checks that a later frame runs cleanly.

// File: rtl/ccd_vseq_pkg.sv
package ccd_vseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CRST  = 3'd1,
    ST_INTG  = 3'd2,
    ST_XFER  = 3'd3,
    ST_SHIFT = 3'd4,
    ST_READ  = 3'd5
  } vseq_st_t;

  localparam int unsigned SUBSTEPS = 8;
  localparam int unsigned N_PHASES = 4;
  localparam int unsigned PH_SPACING = 2;
  localparam int unsigned HIGH_STEPS = 5;

endpackage

// File: rtl/ccd_vseq_phase.sv
module ccd_vseq_phase
  import ccd_vseq_pkg::*;
#(
  parameter int unsigned SUBSTEP_CYC = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  output logic [N_PHASES-1:0] phase,
  output logic                line_end
);

  localparam int unsigned CW = (SUBSTEP_CYC > 1) ? $clog2(SUBSTEP_CYC) : 1;
  localparam logic [CW-1:0] CYC_LAST = CW'(SUBSTEP_CYC - 1);

  logic [CW-1:0] cyc_q, cyc_d;
  logic [2:0]    sub_q, sub_d;
  logic          sub_wrap;

  assign sub_wrap = (cyc_q == CYC_LAST);

  always_comb begin
    if (!run) begin
      cyc_d = '0;
      sub_d = '0;
    end else if (sub_wrap) begin
      cyc_d = '0;
      sub_d = sub_q + 3'd1;
    end else begin
      cyc_d = cyc_q + CW'(1);
      sub_d = sub_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      sub_q <= '0;
    end else begin
      cyc_q <= cyc_d;
      sub_q <= sub_d;
    end
  end

  assign line_end = run && sub_wrap && (sub_q == 3'(SUBSTEPS - 1));

  for (genvar k = 0; k < N_PHASES; k++) begin : g_ph
    localparam logic [2:0] OFS = 3'(PH_SPACING * k);
    logic [2:0] rel;
    assign rel      = sub_q - OFS;
    assign phase[k] = (rel <= 3'(HIGH_STEPS - 1));
  end

endmodule

// File: rtl/ccd_vseq_timer.sv
module ccd_vseq_timer #(
  parameter int unsigned TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  output logic             last
);

  logic [TMR_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - TMR_W'(1);
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last = (cnt_q <= TMR_W'(1));

endmodule

// File: rtl/ccd_vseq_linecnt.sv
module ccd_vseq_linecnt #(
  parameter int unsigned N_LINES = 1030
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       inc,
  output logic [$clog2(N_LINES)-1:0] idx,
  output logic                       last
);

  localparam int unsigned LW = $clog2(N_LINES);
  localparam logic [LW-1:0] IDX_LAST = LW'(N_LINES - 1);

  logic [LW-1:0] idx_q, idx_d;

  assign last = (idx_q == IDX_LAST);

  always_comb begin
    idx_d = idx_q;
    if (inc) idx_d = last ? '0 : idx_q + LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign idx = idx_q;

endmodule

// File: rtl/ccd_vseq.sv
module ccd_vseq
  import ccd_vseq_pkg::*;
#(
  parameter int unsigned N_LINES     = 1030,
  parameter int unsigned SUBSTEP_CYC = 4,
  parameter int unsigned TMR_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             line_done,
  input  logic [TMR_W-1:0] cr_cycles,
  input  logic [TMR_W-1:0] int_cycles,
  output logic [3:0]       img_ph,
  output logic [3:0]       sto_ph,
  output logic             xfer_boost,
  output logic             chg_rst,
  output logic             frame_mark,
  output logic             clamp,
  output logic             hrun
);

  localparam int unsigned LW = $clog2(N_LINES);

  vseq_st_t st_q, st_d;

  logic             run;
  logic             line_end;
  logic [3:0]       phase;
  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_last;
  logic             ln_inc;
  logic             ln_last;
  logic [LW-1:0]    ln_idx;
  logic             clamp_q, clamp_d;

  ccd_vseq_phase #(.SUBSTEP_CYC(SUBSTEP_CYC)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .phase    (phase),
    .line_end (line_end)
  );

  ccd_vseq_timer #(.TMR_W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  ccd_vseq_linecnt #(.N_LINES(N_LINES)) u_lines (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (ln_inc),
    .idx   (ln_idx),
    .last  (ln_last)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (frame_start)          st_d = ST_CRST;
      ST_CRST:  if (tmr_last)             st_d = ST_INTG;
      ST_INTG:  if (tmr_last)             st_d = ST_XFER;
      ST_XFER:  if (line_end && ln_last)  st_d = ST_SHIFT;
      ST_SHIFT: if (line_end)             st_d = ST_READ;
      ST_READ:  if (line_done)            st_d = ln_last ? ST_IDLE : ST_SHIFT;
      default:                            st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = cr_cycles;
    if (st_q == ST_IDLE && frame_start) begin
      tmr_load = 1'b1;
      tmr_val  = cr_cycles;
    end else if (st_q == ST_CRST && tmr_last) begin
      tmr_load = 1'b1;
      tmr_val  = int_cycles;
    end
  end

  assign run    = (st_q == ST_XFER) || (st_q == ST_SHIFT);
  assign ln_inc = ((st_q == ST_XFER) && line_end) ||
                  ((st_q == ST_READ) && line_done);

  assign clamp_d = (st_q == ST_SHIFT) && line_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clamp_q <= 1'b0;
    else        clamp_q <= clamp_d;
  end

  assign img_ph     = (st_q == ST_XFER) ? phase : 4'b0000;
  assign sto_ph     = run ? phase : 4'b0000;
  assign xfer_boost = (st_q == ST_XFER);
  assign chg_rst    = (st_q == ST_CRST);
  assign hrun       = (st_q == ST_READ);
  assign clamp      = clamp_q;
  assign frame_mark = ((st_q == ST_SHIFT) || (st_q == ST_READ)) && (ln_idx == '0);

endmodule

// File: rtl/ccd_vseq_chk.sv
module ccd_vseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] img_ph,
  input logic [3:0] sto_ph,
  input logic       xfer_boost,
  input logic       chg_rst,
  input logic       frame_mark,
  input logic       clamp,
  input logic       hrun
);

  // R4: image and storage phases move together during the full transfer
  a_r4_groups_locked: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_boost |-> (img_ph == sto_ph));

  // R4: no horizontal run while the image section is transported
  a_r4_no_hrun_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_boost |-> !hrun);

  // R5: an active phase group always has 2 or 3 phases high
  a_r5_phase_count: assert property (@(posedge clk) disable iff (!rst_n)
    (sto_ph != 4'b0000) |-> ($countones(sto_ph) inside {2, 3}));

  // R5: consecutive patterns in a shift differ in at most one phase
  a_r5_one_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_boost && $past(xfer_boost)) |-> ($countones(sto_ph ^ $past(sto_ph)) <= 1));

  // R6: storage-only shift keeps the image phases quiet
  a_r6_img_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_boost |-> (img_ph == 4'b0000));

  // R7: horizontal run never overlaps a vertical shift
  a_r7_hrun_excl: assert property (@(posedge clk) disable iff (!rst_n)
    hrun |-> (sto_ph == 4'b0000));

  // R8: clamp only inside a line read, one cycle wide
  a_r8_clamp_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    clamp |-> hrun);
  a_r8_clamp_single: assert property (@(posedge clk) disable iff (!rst_n)
    clamp |=> !clamp);

  // R2: charge reset excludes every other activity
  a_r2_cr_alone: assert property (@(posedge clk) disable iff (!rst_n)
    chg_rst |-> (!xfer_boost && !hrun && !frame_mark && !clamp && sto_ph == 4'b0000));

endmodule

bind ccd_vseq ccd_vseq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .img_ph     (img_ph),
  .sto_ph     (sto_ph),
  .xfer_boost (xfer_boost),
  .chg_rst    (chg_rst),
  .frame_mark (frame_mark),
  .clamp      (clamp),
  .hrun       (hrun)
);

// File: tb/ccd_vseq_tb.sv
module ccd_vseq_tb;

  localparam int LINES = 6;
  localparam int STEP  = 2;
  localparam int TW    = 8;
  localparam int SHIFT_LEN = 8 * STEP;

  // each row: {cr_cycles, int_cycles, noise flag}
  localparam logic [23:0] VEC [0:3] = '{
    {8'd3, 8'd5, 8'd0},
    {8'd0, 8'd0, 8'd1},
    {8'd1, 8'd2, 8'd0},
    {8'd9, 8'd1, 8'd1}
  };

  logic          clk;
  logic          rst_n;
  logic          frame_start;
  logic          line_done;
  logic [TW-1:0] cr_cycles;
  logic [TW-1:0] int_cycles;
  logic [3:0]    img_ph;
  logic [3:0]    sto_ph;
  logic          xfer_boost;
  logic          chg_rst;
  logic          frame_mark;
  logic          clamp;
  logic          hrun;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  ccd_vseq #(.N_LINES(LINES), .SUBSTEP_CYC(STEP), .TMR_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_done(line_done),
    .cr_cycles(cr_cycles), .int_cycles(int_cycles), .img_ph(img_ph), .sto_ph(sto_ph),
    .xfer_boost(xfer_boost), .chg_rst(chg_rst), .frame_mark(frame_mark),
    .clamp(clamp), .hrun(hrun)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_pat(input int idx);
    logic [3:0] p;
    int s;
    s = (idx / STEP) % 8;
    for (int k = 0; k < 4; k++) p[k] = (((s - 2 * k) % 8 + 8) % 8) <= 4;
    return p;
  endfunction

  function automatic int all_out();
    return {img_ph, sto_ph, xfer_boost, chg_rst, frame_mark, clamp, hrun};
  endfunction

  task automatic check_idle(input int cycles, input string rq);
    for (int i = 0; i < cycles; i++) begin
      chk(all_out() == 0, rq, all_out(), 0);
      @(negedge clk);
    end
  endtask

  task automatic run_frame(input int cr, input int it, input bit noise);
    int n, gap, idx, sidx, r, nclamp, w;
    cr_cycles   = TW'(cr);
    int_cycles  = TW'(it);
    chk(all_out() == 0, "R1 idle before frame", all_out(), 0);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    n = 0;
    while (chg_rst && n < 1000) begin
      chk(!xfer_boost && !hrun && sto_ph == 0, "R2 cr exclusive", all_out(), 0);
      n++;
      @(negedge clk);
    end
    chk(n == ((cr > 0) ? cr : 1), "R2 charge reset length", n, (cr > 0) ? cr : 1);
    gap = 0;
    while (!xfer_boost && !chg_rst && gap < 1000) begin
      chk(all_out() == 0, "R3 quiet integration", all_out(), 0);
      gap++;
      @(negedge clk);
    end
    chk(gap == ((it > 0) ? it : 1), "R3 integration length", gap, (it > 0) ? it : 1);
    idx = 0;
    while (xfer_boost && idx < 100000) begin
      chk(img_ph == exp_pat(idx), "R5 image phase pattern", img_ph, exp_pat(idx));
      chk(sto_ph == img_ph, "R4 storage follows image", sto_ph, img_ph);
      chk(!hrun && !frame_mark, "R4 no read during transfer", hrun, 0);
      if (noise) frame_start = (idx == 5);
      idx++;
      @(negedge clk);
    end
    frame_start = 1'b0;
    chk(idx == LINES * SHIFT_LEN, "R4 transfer length", idx, LINES * SHIFT_LEN);
    for (int l = 0; l < LINES; l++) begin
      sidx = 0;
      while (!hrun && sidx < 1000) begin
        chk(sto_ph == exp_pat(sidx), "R6 storage shift pattern", sto_ph, exp_pat(sidx));
        chk(img_ph == 0 && !xfer_boost, "R6 image quiet", img_ph, 0);
        chk(frame_mark == (l == 0), "R9 frame mark in shift", frame_mark, l == 0);
        line_done = noise;
        sidx++;
        @(negedge clk);
      end
      line_done = 1'b0;
      chk(sidx == SHIFT_LEN, "R7 line_done ignored, shift length", sidx, SHIFT_LEN);
      w = 2 + l;
      r = 0;
      nclamp = 0;
      while (hrun && r < 1000) begin
        chk(clamp == (r == 0), "R8 clamp on first read cycle", clamp, r == 0);
        chk(frame_mark == (l == 0), "R9 frame mark in read", frame_mark, l == 0);
        chk(sto_ph == 0, "R7 no shift during read", sto_ph, 0);
        if (clamp) nclamp++;
        line_done = (r == w);
        r++;
        @(negedge clk);
      end
      line_done = 1'b0;
      chk(r == w + 1, "R7 read waits for line_done", r, w + 1);
      chk(nclamp == 1, "R8 clamp count per line", nclamp, 1);
    end
    check_idle(12, "R10 back to idle, no second frame");
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    rst_n       = 1'b0;
    frame_start = 1'b0;
    line_done   = 1'b0;
    cr_cycles   = '0;
    int_cycles  = '0;
    repeat (3) @(negedge clk);
    check_idle(1, "R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle(4, "R1 idle after reset");

    foreach (VEC[v]) begin
      run_frame(int'(VEC[v][23:16]), int'(VEC[v][15:8]), VEC[v][0]);
    end

    // directed: line_done and trigger noise while idle do nothing
    line_done = 1'b1;
    @(negedge clk);
    line_done = 1'b0;
    check_idle(5, "R10 line_done in idle ignored");

    // directed: reset in the middle of the transfer
    cr_cycles   = 8'd2;
    int_cycles  = 8'd2;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    repeat (10) @(negedge clk);
    chk(xfer_boost == 1'b1, "R4 transfer reached", xfer_boost, 1);
    rst_n = 1'b0;
    #1;
    chk(all_out() == 0, "R1 async reset clears outputs", all_out(), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle(5, "R1 idle after mid-frame reset");
    run_frame(4, 3, 1'b0);

    done = 1'b1;
    report();
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      report();
    end
  end

endmodule